// File: doc/BRIEF.md
# Two-Part Interframe Deferral Timer

This block decides when a 10 Mb/s half-duplex MAC may begin a queued transmission once the medium falls silent. A counter advances on a bit-time tick and measures the interframe gap. The gap has two parts. In the first part, carrier can send the timer back to the start. In the second part, carrier has no effect, so a station that is already committed transmits when the gap ends.

After the MAC's own frame, carrier sense is masked for a fixed blinding window that begins as the transmission ends. This covers the self-test burst a transceiver returns. The window lies inside the first part of the gap. Carrier that appears after the window but before the first part ends restarts only the gap, never the window. An enable input selects whether the gap that follows the MAC's own frame is split in this way. When it is off, that gap runs to the end without regard to carrier.

The MAC holds a pending request. The block answers with a one-cycle grant and reports its current phase.

Top module: `defer_ifs_timer`

## Requirements
- R1: Out of reset, `gap_phase` is idle (0), the gap counts as already met, and `tx_go` is low. A request raised on a quiet idle medium is granted in the following cycle.
- R2: Carrier seen in the idle phase moves the block to busy (1). No grant is issued while the block is busy.
- R3: When receive carrier drops, the block enters the open phase (2) with the gap count at zero. Unmasked carrier in the open phase returns the block to busy, and the full gap restarts afterwards.
- R4: After `PART1_BITS` ticks in the open phase, the block enters the locked phase (3). While locked, carrier neither restarts nor stops the count.
- R5: When the `GAP_BITS`-th tick of the gap lands, the block returns to idle. `tx_go` pulses in the next cycle if `tx_pending` is high, even if carrier is present.
- R6: `tx_go` lasts one cycle. A request that stays high is granted once. A new grant needs `tx_pending` to fall or `transmitting` to assert first.
- R7: `transmitting` forces the busy phase. When it drops with `post_tx_split_en` high, the block enters the open phase and ignores carrier for the first `BLIND_BITS` ticks.
- R8: Carrier after the blinding window but inside the first part restarts the gap. It does not restart the blinding window, so carrier early in the new gap is honoured.
- R9: With `post_tx_split_en` low, the end of a transmission leads straight to the locked phase. Carrier cannot restart that gap.
- R10: `gap_phase` encoding is idle=0, busy=1, open=2, locked=3, and it always agrees with the timing rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| carrier_sense | input | 1 | Medium activity |
| transmitting | input | 1 | MAC is sending its own frame |
| tx_pending | input | 1 | MAC has a frame waiting |
| post_tx_split_en | input | 1 | Split the gap after the MAC's own frame |
| tx_go | output | 1 | One-cycle transmit grant |
| gap_phase | output | 2 | Current phase, encoded as in R10 |

## Verification
The bench builds the block with its default 96/60/40 bit-time split and raises one tick every other clock, so a full gap takes about two hundred cycles. This brings every phase boundary within reach, including the 39th and 40th ticks of the blinding window, the 59th and 60th ticks of the first part, and a grant on the final tick while carrier is high. A behavioural model is compared against the phase and the grant on every cycle. Targeted checks cover re-arming after a held request and the gap after a transmission with the split disabled.

// File: rtl/defer_pkg.sv
`timescale 1ns/1ps
// Shared types for the interframe deferral timer.
package defer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // gap met, medium free for a grant
        PH_BUSY = 2'd1,   // carrier or own transmission in progress
        PH_OPEN = 2'd2,   // first part of the gap, carrier may restart it
        PH_LOCK = 2'd3    // final part of the gap, carrier ignored
    } phase_e;
endpackage

// File: rtl/defer_gap_counter.sv
`timescale 1ns/1ps
// Gap counter: counts bit ticks since the gap began and flags the tick that
// reaches each boundary. Assumes BLIND_BITS < PART1_BITS < GAP_BITS.
// Resets to GAP_BITS, so the gap reads as already met.
module defer_gap_counter #(
    parameter int GAP_BITS   = 96,
    parameter int PART1_BITS = 60,
    parameter int BLIND_BITS = 40,
    localparam int CW        = $clog2(GAP_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          hit_blind,
    output logic          hit_part1,
    output logic          hit_gap
);
    // Count register: clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= CW'(GAP_BITS);
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // Boundary flags: true on the tick that moves the count onto a boundary.
    always_comb begin
        hit_blind = inc && !clr && (cnt == CW'(BLIND_BITS - 1));
        hit_part1 = inc && !clr && (cnt == CW'(PART1_BITS - 1));
        hit_gap   = inc && !clr && (cnt == CW'(GAP_BITS - 1));
    end
endmodule

// File: rtl/defer_flag.sv
`timescale 1ns/1ps
// Set/clear flag. Used for the carrier blinding window.
// Clear wins when both are requested.
module defer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
    end
endmodule

// File: rtl/defer_grant.sv
`timescale 1ns/1ps
// Grant stage: registers the grant request as a one-cycle pulse and records
// that the current request was served. The record clears when the request
// drops or the MAC starts to transmit.
module defer_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tx_pending,
    input  logic transmitting,
    output logic tx_go,
    output logic granted
);
    // Pulse and served-request record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_go   <= 1'b0;
            granted <= 1'b0;
        end else begin
            tx_go <= req;
            if (req)                              granted <= 1'b1;
            else if (!tx_pending || transmitting) granted <= 1'b0;
        end
    end
endmodule

// File: rtl/defer_ifs_timer.sv
`timescale 1ns/1ps
// Two-part interframe deferral timer (top). Sequences the idle, busy, open
// and locked phases, steers the gap counter and the blinding flag, and
// requests grants. Assumes bit_tick is a one-cycle pulse and that
// BLIND_BITS < PART1_BITS < GAP_BITS.
module defer_ifs_timer
    import defer_pkg::*;
#(
    parameter int GAP_BITS   = 96,
    parameter int PART1_BITS = 60,
    parameter int BLIND_BITS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       carrier_sense,
    input  logic       transmitting,
    input  logic       tx_pending,
    input  logic       post_tx_split_en,
    output logic       tx_go,
    output logic [1:0] gap_phase
);
    localparam int CW = $clog2(GAP_BITS + 1);

    phase_e        phase_q, phase_n;
    logic          own_q, own_n;
    logic          cnt_clr, cnt_inc, blind_set, blind_clr, grant_req;
    logic          hit_blind, hit_part1, hit_gap, blind_q, granted;
    logic [CW-1:0] gap_cnt;

    defer_gap_counter #(
        .GAP_BITS  (GAP_BITS),
        .PART1_BITS(PART1_BITS),
        .BLIND_BITS(BLIND_BITS)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .cnt(gap_cnt), .hit_blind(hit_blind), .hit_part1(hit_part1),
        .hit_gap(hit_gap)
    );

    defer_flag u_blind (
        .clk(clk), .rst_n(rst_n), .set(blind_set), .clr(blind_clr), .q(blind_q)
    );

    defer_grant u_grant (
        .clk(clk), .rst_n(rst_n), .req(grant_req), .tx_pending(tx_pending),
        .transmitting(transmitting), .tx_go(tx_go), .granted(granted)
    );

    // Next-phase and control decode; own transmission overrides everything.
    always_comb begin
        phase_n   = phase_q;
        own_n     = own_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        blind_set = 1'b0;
        blind_clr = 1'b0;
        grant_req = 1'b0;
        if (transmitting) begin
            phase_n   = PH_BUSY;
            own_n     = 1'b1;
            cnt_clr   = 1'b1;
            blind_clr = 1'b1;
        end else begin
            unique case (phase_q)
                PH_BUSY: begin
                    if (own_q) begin
                        own_n   = 1'b0;
                        cnt_clr = 1'b1;
                        if (post_tx_split_en) begin
                            phase_n   = PH_OPEN;
                            blind_set = 1'b1;
                        end else begin
                            phase_n   = PH_LOCK;
                        end
                    end else if (!carrier_sense) begin
                        phase_n = PH_OPEN;
                        cnt_clr = 1'b1;
                    end
                end
                PH_OPEN: begin
                    if (carrier_sense && !blind_q) begin
                        phase_n = PH_BUSY;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc   = bit_tick;
                        blind_clr = hit_blind;
                        if (hit_part1) phase_n = PH_LOCK;
                    end
                end
                PH_LOCK: begin
                    cnt_inc = bit_tick;
                    if (hit_gap) begin
                        phase_n   = PH_IDLE;
                        grant_req = tx_pending && !granted;
                    end
                end
                PH_IDLE: begin
                    if (carrier_sense) phase_n   = PH_BUSY;
                    else               grant_req = tx_pending && !granted;
                end
            endcase
        end
    end

    // Phase and own-frame record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            own_q   <= 1'b0;
        end else begin
            phase_q <= phase_n;
            own_q   <= own_n;
        end
    end

    assign gap_phase = phase_q;
endmodule

// File: rtl/defer_ifs_checker.sv
`timescale 1ns/1ps
// Assertion checker for defer_ifs_timer, attached by bind below.
module defer_ifs_checker
    import defer_pkg::*;
#(
    parameter int GAP_BITS = 96,
    parameter int CW       = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          transmitting,
    input logic          tx_pending,
    input logic          tx_go,
    input logic [1:0]    gap_phase,
    input logic          blind,
    input logic [CW-1:0] gap_cnt
);
    p_go_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |=> !tx_go);

    p_go_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> $past(tx_pending));

    p_busy_no_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_phase == PH_BUSY) |=> !tx_go);

    p_open_starts_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_phase == PH_OPEN && $past(gap_phase) == PH_BUSY) |-> (gap_cnt == '0));

    p_lock_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_phase == PH_LOCK && !transmitting) |=>
            (gap_phase == PH_LOCK || gap_phase == PH_IDLE));

    p_tx_forces_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        transmitting |=> (gap_phase == PH_BUSY));

    p_blind_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_phase == PH_OPEN && blind && !transmitting) |=> (gap_phase != PH_BUSY));

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= CW'(GAP_BITS));
endmodule

bind defer_ifs_timer defer_ifs_checker #(
    .GAP_BITS(GAP_BITS),
    .CW($clog2(GAP_BITS + 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .transmitting(transmitting),
    .tx_pending(tx_pending), .tx_go(tx_go), .gap_phase(gap_phase),
    .blind(blind_q), .gap_cnt(gap_cnt)
);

// File: tb/tb_defer_ifs_timer.sv
`timescale 1ns/1ps
// Bench for defer_ifs_timer: a behavioural model checked on every cycle,
// plus directed checks at the phase boundaries.
module tb_defer_ifs_timer;
    localparam int GAP   = 96;
    localparam int PART1 = 60;
    localparam int BLIND = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_tick = 1'b0, carrier_sense = 1'b0, transmitting = 1'b0;
    logic tx_pending = 1'b0, post_tx_split_en = 1'b1;
    logic tx_go;
    logic [1:0] gap_phase;

    int n_chk = 0, n_fail = 0, go_seen = 0, g0 = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    defer_ifs_timer #(.GAP_BITS(GAP), .PART1_BITS(PART1), .BLIND_BITS(BLIND)) dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier_sense(carrier_sense),
        .transmitting(transmitting), .tx_pending(tx_pending),
        .post_tx_split_en(post_tx_split_en), .tx_go(tx_go), .gap_phase(gap_phase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model of the requirements, evaluated at each rising edge.
    int m_ph = 0, m_cnt = GAP, nph, ncnt;
    bit m_blind = 0, m_own = 0, m_gr = 0, m_go = 0, nbl, nown, rq;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = GAP; m_blind = 0; m_own = 0; m_gr = 0; m_go = 0;
        end else begin
            nph = m_ph; ncnt = m_cnt; nbl = m_blind; nown = m_own; rq = 0;
            if (transmitting) begin
                nph = 1; nown = 1; ncnt = 0; nbl = 0;
            end else if (m_ph == 1) begin
                if (m_own) begin
                    nown = 0; ncnt = 0; nph = post_tx_split_en ? 2 : 3; nbl = post_tx_split_en;
                end else if (!carrier_sense) begin
                    nph = 2; ncnt = 0;
                end
            end else if (m_ph == 2) begin
                if (carrier_sense && !m_blind) begin
                    nph = 1; ncnt = 0;
                end else if (bit_tick) begin
                    ncnt = m_cnt + 1;
                    if (ncnt == BLIND) nbl = 0;
                    if (ncnt == PART1) nph = 3;
                end
            end else if (m_ph == 3) begin
                if (bit_tick) begin
                    ncnt = m_cnt + 1;
                    if (ncnt == GAP) begin nph = 0; rq = tx_pending && !m_gr; end
                end
            end else begin
                if (carrier_sense) nph = 1;
                else rq = tx_pending && !m_gr;
            end
            m_go = rq;
            if (rq) m_gr = 1;
            else if (!tx_pending || transmitting) m_gr = 0;
            m_ph = nph; m_cnt = ncnt; m_blind = nbl; m_own = nown;
        end
    end

    // Every-cycle comparison and grant counting, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 phase vs model", int'(gap_phase), m_ph);
            chk("R5 tx_go vs model", int'(tx_go), int'(m_go));
            if (tx_go) go_seen++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset phase", int'(gap_phase), 0);
        chk("R1 reset tx_go", int'(tx_go), 0);

        // Immediate grant on an idle medium, then a single pulse.
        tx_pending = 1'b1;
        step(1);
        chk("R1 idle grant", int'(tx_go), 1);
        step(1);
        chk("R6 pulse width", int'(tx_go), 0);
        step(3);
        chk("R6 no regrant", int'(tx_go), 0);
        tx_pending = 1'b0;
        step(1);

        // Receive, restart in the first part, carrier ignored when locked.
        carrier_sense = 1'b1;
        step(1);
        chk("R2 busy on carrier", int'(gap_phase), 1);
        tx_pending = 1'b1; g0 = go_seen;
        step(4);
        step(1);
        chk("R2 no grant busy", go_seen - g0, 0);
        tx_pending = 1'b0;
        carrier_sense = 1'b0;
        step(1);
        chk("R3 open after carrier", int'(gap_phase), 2);
        tick_n(30);
        carrier_sense = 1'b1;
        step(1);
        chk("R3 carrier restarts", int'(gap_phase), 1);
        carrier_sense = 1'b0;
        step(1);
        tick_n(PART1 - 1);
        chk("R3 full count restarted", int'(gap_phase), 2);
        tick_n(1);
        chk("R4 locked at part1", int'(gap_phase), 3);
        carrier_sense = 1'b1;
        tick_n(10);
        chk("R4 carrier ignored", int'(gap_phase), 3);
        tx_pending = 1'b1; g0 = go_seen;
        tick_n(GAP - PART1 - 11);
        step(1);
        chk("R5 no early grant", go_seen - g0, 0);
        tick_n(1);
        step(1);
        chk("R5 grant at gap end busy medium", go_seen - g0, 1);
        chk("R2 busy after grant", int'(gap_phase), 1);

        // Own transmission with split gap and blinding window.
        carrier_sense = 1'b0;
        transmitting = 1'b1;
        step(3);
        chk("R7 busy while tx", int'(gap_phase), 1);
        tx_pending = 1'b0;
        transmitting = 1'b0; carrier_sense = 1'b1;
        step(1);
        chk("R7 open after tx", int'(gap_phase), 2);
        tick_n(BLIND - 1);
        chk("R7 carrier blinded", int'(gap_phase), 2);
        tick_n(1);
        chk("R8 carrier after blind restarts", int'(gap_phase), 1);
        carrier_sense = 1'b0;
        step(1);
        tick_n(5);
        carrier_sense = 1'b1;
        step(1);
        chk("R8 blind not restarted", int'(gap_phase), 1);
        carrier_sense = 1'b0;
        step(1);
        tx_pending = 1'b1; g0 = go_seen;
        tick_n(GAP - 1);
        step(1);
        chk("R5 no early grant", go_seen - g0, 0);
        tick_n(1);
        step(1);
        chk("R5 grant after gap", go_seen - g0, 1);
        chk("R5 idle after gap", int'(gap_phase), 0);
        step(3);
        chk("R6 held request once", go_seen - g0, 1);
        tx_pending = 1'b0;
        step(1);
        tx_pending = 1'b1;
        step(2);
        chk("R6 rearmed by drop", go_seen - g0, 2);
        tx_pending = 1'b0;

        // Split disabled after transmission.
        post_tx_split_en = 1'b0;
        transmitting = 1'b1;
        step(2);
        transmitting = 1'b0; carrier_sense = 1'b1;
        step(1);
        chk("R9 locked after tx", int'(gap_phase), 3);
        tick_n(50);
        chk("R9 carrier ignored", int'(gap_phase), 3);
        carrier_sense = 1'b0;
        tx_pending = 1'b1; g0 = go_seen;
        tick_n(GAP - 50);
        step(1);
        chk("R9 grant at gap end", go_seen - g0, 1);
        chk("R9 idle", int'(gap_phase), 0);
        tx_pending = 1'b0;
        step(2);
        finish_run();
    end
endmodule